// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error Flags

This block turns an asynchronous serial line into parallel characters. A 16x sample-rate enable pulse paces it. The line idles high. A character starts with a high-to-low transition and is confirmed at the middle of the start bit. Then come seven or eight data bits, least significant first, an optional parity bit and a stop bit. Each of these bits is sampled once, at the middle of its bit period.

A finished character moves into a holding register, and a buffer-full flag tells the host that a character is waiting. Three sticky flags report problems:
- a wrong parity bit,
- a character that overwrote an unread one,
- a stop bit sampled low.

The host clears the buffer-full flag with a read strobe. The error flags clear only on a dedicated clear strobe, or while the receiver is disabled. The frame format comes from three static mode inputs. A receiver-only reset returns the bit engine to idle and empties the buffer-full flag. The host bus decode, the baud-rate divider and interrupt masking are outside this block.

Top module: `urx_receiver`

## Requirements
- R1: A character is started only when, on a sample tick, the line is low and was high on the previous sample tick. A line held high starts nothing.
- R2: The start bit is re-sampled 8 ticks after the tick that saw the falling edge. If the line is high at that point, the receiver returns to idle and loads no character.
- R3: With cfg_eight_bits=1, eight data bits are taken least significant bit first, each sampled 16 ticks after the previous sample point. They appear on rx_data[7:0] when the character is loaded.
- R4: With cfg_eight_bits=0, seven data bits are taken into rx_data[6:0], and rx_data[7] reads 0.
- R5: With cfg_parity_en=1, one parity bit follows the data. parity_err is set when the XOR of the data bits and the parity bit differs from cfg_parity_odd (0 = even, 1 = odd). With cfg_parity_en=0, no parity bit is expected and parity_err is never set.
- R6: framing_err is set when the stop bit is sampled low. The character is still loaded.
- R7: buf_full rises one cycle after a character is loaded. A host_read pulse clears it on the next cycle, and so does rx_reset. The loaded data stays on rx_data.
- R8: overrun_err is set when a character is loaded while buf_full is already set and no host_read arrives in the same cycle. rx_data then holds the newer character.
- R9: parity_err, overrun_err and framing_err are sticky. host_read leaves them unchanged, and an err_clear pulse clears them. A new error in the same cycle as err_clear is kept.
- R10: While rx_enable is 0, no character is loaded, buf_full cannot be set, rx_data is unchanged, and all three error flags are held at 0.
- R11: After rst_n is asserted low, buf_full, the three error flags and rx_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous internal reset, active low |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rx_serial | input | 1 | Serial input line, idle high |
| rx_enable | input | 1 | Receiver enable |
| rx_reset | input | 1 | Receiver-only reset, synchronous, active high |
| err_clear | input | 1 | One-cycle strobe that clears the error flags |
| host_read | input | 1 | One-cycle strobe marking the host read of rx_data |
| cfg_eight_bits | input | 1 | 1 = eight data bits, 0 = seven |
| cfg_parity_en | input | 1 | 1 = a parity bit is present and checked |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_data | output | 8 | Holding register contents |
| buf_full | output | 1 | A character is waiting for the host |
| parity_err | output | 1 | Sticky parity error flag |
| overrun_err | output | 1 | Sticky overrun flag |
| framing_err | output | 1 | Sticky framing error flag |

## Verification
The assertions watch, on every cycle, the rules that govern the flags:
- the bit engine leaves idle only on a sampled falling edge;
- buf_full rises only after a character is loaded, and drops after a read;
- overrun appears only when a character arrives into an unread buffer;
- error flags fall only through err_clear or disable, and stay clear while disabled;
- the top bit stays zero in seven-bit mode.

Only the bench scenarios can show that the right bits are sampled in the right order, and that a bad parity bit or a low stop bit raises the matching flag. They also cover rejection of a short start pulse, and a sweep over all eight frame formats. There, the expected character and parity are computed from the byte sent.

// File: rtl/urx_pkg.sv
package urx_pkg;

  localparam int URX_MAX_BITS = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } urx_state_e;

  // Number of data bits in the frame for the current mode.
  function automatic logic [3:0] urx_data_bits(input logic eight);
    return eight ? 4'd8 : 4'd7;
  endfunction

  // Index of the last data bit of the frame.
  function automatic logic [2:0] urx_last_index(input logic eight);
    return eight ? 3'd7 : 3'd6;
  endfunction

  // Returns 1 when the parity bit disagrees with the selected sense.
  // Total ones over data and parity bit: even when odd=0, odd when odd=1.
  function automatic logic urx_parity_bad(input logic [URX_MAX_BITS-1:0] d,
                                          input logic eight,
                                          input logic pbit,
                                          input logic odd);
    logic ones;
    ones = (^d[URX_MAX_BITS-2:0]) ^ (eight & d[URX_MAX_BITS-1]) ^ pbit;
    return ones != odd;
  endfunction

endpackage

// File: rtl/urx_bit_engine.sv
module urx_bit_engine
  import urx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    rx,
  input  logic                    run,
  input  logic                    cfg_eight,
  input  logic                    cfg_pen,
  input  logic                    cfg_odd,
  output logic                    char_done,
  output logic [URX_MAX_BITS-1:0] char_data,
  output logic                    char_perr,
  output logic                    char_ferr,
  output logic                    fall_seen
);

  localparam int CW = $clog2(OVERSAMPLE);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(OVERSAMPLE - 1);

  urx_state_e              state;
  logic [CW-1:0]           cnt;
  logic [2:0]              idx;
  logic                    prev;
  logic                    pbit;
  logic [URX_MAX_BITS-1:0] shreg;
  logic                    sample_pt;
  logic                    in_frame;

  assign in_frame  = (state == RX_DATA) || (state == RX_PAR) || (state == RX_STOP);
  assign fall_seen = tick && (state == RX_IDLE) && prev && !rx;
  assign sample_pt = tick && (((state == RX_START) && (cnt == HALF_LAST)) ||
                              (in_frame && (cnt == FULL_LAST)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      prev      <= 1'b1;
      pbit      <= 1'b0;
      shreg     <= '0;
      char_done <= 1'b0;
      char_perr <= 1'b0;
      char_ferr <= 1'b0;
    end else begin
      char_done <= 1'b0;
      if (!run) begin
        state <= RX_IDLE;
        cnt   <= '0;
        if (tick) prev <= rx;
      end else if (tick) begin
        prev <= rx;
        cnt  <= sample_pt ? '0 : cnt + 1'b1;
        unique case (state)
          RX_IDLE: begin
            cnt <= '0;
            if (fall_seen) state <= RX_START;
          end
          RX_START: begin
            if (sample_pt) begin
              if (rx) begin
                state <= RX_IDLE;
              end else begin
                state <= RX_DATA;
                idx   <= '0;
                shreg <= '0;
              end
            end
          end
          RX_DATA: begin
            if (sample_pt) begin
              shreg[idx] <= rx;
              if (idx == urx_last_index(cfg_eight)) state <= cfg_pen ? RX_PAR : RX_STOP;
              else idx <= idx + 1'b1;
            end
          end
          RX_PAR: begin
            if (sample_pt) begin
              pbit  <= rx;
              state <= RX_STOP;
            end
          end
          RX_STOP: begin
            if (sample_pt) begin
              char_done <= 1'b1;
              char_ferr <= !rx;
              char_perr <= cfg_pen && urx_parity_bad(shreg, cfg_eight, pbit, cfg_odd);
              state     <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign char_data = shreg;

  // R1: the start phase is entered only from a sampled falling edge
  a_r1_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state != RX_START) |=> ((state != RX_START) || $past(fall_seen)));

  // R4: seven-bit characters never carry a top bit
  a_r4_seven_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !cfg_eight) |-> (char_data[URX_MAX_BITS-1] == 1'b0));

endmodule

// File: rtl/urx_flag_bank.sv
module urx_flag_bank
  import urx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_enable,
  input  logic                    rx_reset,
  input  logic                    err_clear,
  input  logic                    host_read,
  input  logic                    char_done,
  input  logic [URX_MAX_BITS-1:0] char_data,
  input  logic                    char_perr,
  input  logic                    char_ferr,
  output logic [URX_MAX_BITS-1:0] hold_data,
  output logic                    buf_full,
  output logic                    parity_err,
  output logic                    overrun_err,
  output logic                    framing_err
);

  logic accept;
  logic overrun_evt;

  assign accept      = char_done && rx_enable;
  assign overrun_evt = accept && buf_full && !host_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data   <= '0;
      buf_full    <= 1'b0;
      parity_err  <= 1'b0;
      overrun_err <= 1'b0;
      framing_err <= 1'b0;
    end else begin
      if (accept) hold_data <= char_data;

      if (rx_reset)       buf_full <= 1'b0;
      else if (accept)    buf_full <= 1'b1;
      else if (host_read) buf_full <= 1'b0;

      if (!rx_enable) begin
        parity_err  <= 1'b0;
        overrun_err <= 1'b0;
        framing_err <= 1'b0;
      end else begin
        parity_err  <= (parity_err  && !err_clear) || (accept && char_perr);
        overrun_err <= (overrun_err && !err_clear) || overrun_evt;
        framing_err <= (framing_err && !err_clear) || (accept && char_ferr);
      end
    end
  end

  // R7: the buffer-full flag rises only after an accepted character
  a_r7_full_needs_char: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> $past(char_done && rx_enable));

  // R7: a read with no incoming character empties the buffer
  a_r7_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (host_read && !char_done) |=> !buf_full);

  // R8: overrun appears only when a character lands in an unread buffer
  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_err) |-> $past(char_done && buf_full && !host_read));

  // R9: error flags drop only through the clear strobe or disable
  a_r9_sticky_errors: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(parity_err) || $fell(overrun_err) || $fell(framing_err))
      |-> $past(err_clear || !rx_enable));

  // R10: disabled receiver keeps every error flag clear
  a_r10_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (!parity_err && !overrun_err && !framing_err));

endmodule

// File: rtl/urx_receiver.sv
module urx_receiver
  import urx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_serial,
  input  logic       rx_enable,
  input  logic       rx_reset,
  input  logic       err_clear,
  input  logic       host_read,
  input  logic       cfg_eight_bits,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  output logic [7:0] rx_data,
  output logic       buf_full,
  output logic       parity_err,
  output logic       overrun_err,
  output logic       framing_err
);

  logic                    run;
  logic                    char_done;
  logic [URX_MAX_BITS-1:0] char_data;
  logic                    char_perr;
  logic                    char_ferr;
  logic                    fall_seen;

  assign run = rx_enable && !rx_reset;

  urx_bit_engine #(.OVERSAMPLE(OVERSAMPLE)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rx        (rx_serial),
    .run       (run),
    .cfg_eight (cfg_eight_bits),
    .cfg_pen   (cfg_parity_en),
    .cfg_odd   (cfg_parity_odd),
    .char_done (char_done),
    .char_data (char_data),
    .char_perr (char_perr),
    .char_ferr (char_ferr),
    .fall_seen (fall_seen)
  );

  urx_flag_bank u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .rx_reset    (rx_reset),
    .err_clear   (err_clear),
    .host_read   (host_read),
    .char_done   (char_done),
    .char_data   (char_data),
    .char_perr   (char_perr),
    .char_ferr   (char_ferr),
    .hold_data   (rx_data),
    .buf_full    (buf_full),
    .parity_err  (parity_err),
    .overrun_err (overrun_err),
    .framing_err (framing_err)
  );

endmodule

// File: tb/urx_receiver_tb.sv
module urx_receiver_tb;

  localparam int DIV     = 3;
  localparam int BIT_CLK = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       rx_serial = 1'b1;
  logic       rx_enable = 1'b1;
  logic       rx_reset = 1'b0;
  logic       err_clear = 1'b0;
  logic       host_read = 1'b0;
  logic       cfg_eight_bits = 1'b1;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_parity_odd = 1'b0;
  logic [7:0] rx_data;
  logic       buf_full, parity_err, overrun_err, framing_err;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;
  int tcnt = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) tcnt <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
  assign tick16 = (tcnt == 0);

  urx_receiver u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial),
    .rx_enable(rx_enable), .rx_reset(rx_reset), .err_clear(err_clear),
    .host_read(host_read), .cfg_eight_bits(cfg_eight_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .rx_data(rx_data), .buf_full(buf_full), .parity_err(parity_err),
    .overrun_err(overrun_err), .framing_err(framing_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hold_bit(input logic v);
    rx_serial = v;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  function automatic logic [7:0] masked(input logic [7:0] d, input logic eight);
    return eight ? d : {1'b0, d[6:0]};
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_val);
    logic [7:0] m;
    m = masked(d, cfg_eight_bits);
    hold_bit(1'b0);
    for (int i = 0; i < (cfg_eight_bits ? 8 : 7); i++) hold_bit(d[i]);
    if (cfg_parity_en) hold_bit((^m) ^ cfg_parity_odd ^ flip_par);
    hold_bit(stop_val);
    hold_bit(1'b1);
  endtask

  task automatic pulse_read();
    @(negedge clk) host_read = 1'b1;
    @(negedge clk) host_read = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk) err_clear = 1'b1;
    @(negedge clk) err_clear = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_rxreset();
    @(negedge clk) rx_reset = 1'b1;
    @(negedge clk) rx_reset = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] prev_data;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk("R11", "buf_full", {7'd0, buf_full}, 8'd0);
    chk("R11", "errors", {5'd0, parity_err, overrun_err, framing_err}, 8'd0);
    chk("R11", "rx_data", rx_data, 8'd0);
    rst_n = 1'b1;

    // R1: idle high line starts nothing
    repeat (20 * BIT_CLK) @(negedge clk);
    chk("R1", "idle buf_full", {7'd0, buf_full}, 8'd0);

    // R3 R4 R5 R7 R9: sweep every frame format
    for (int cfg = 0; cfg < 8; cfg++) begin
      cfg_eight_bits = cfg[0];
      cfg_parity_en  = cfg[1];
      cfg_parity_odd = cfg[2];
      for (int k = 0; k < 8; k++) begin
        d = 8'(k * 37 + cfg * 11 + 5);
        send_frame(d, 1'b0, 1'b1);
        chk(cfg_eight_bits ? "R3" : "R4", "rx_data", rx_data, masked(d, cfg_eight_bits));
        chk("R7", "full after load", {7'd0, buf_full}, 8'd1);
        chk("R5", "no parity err", {7'd0, parity_err}, 8'd0);
        chk("R6", "no framing err", {7'd0, framing_err}, 8'd0);
        pulse_read();
        chk("R7", "read empties", {7'd0, buf_full}, 8'd0);
        chk("R7", "data kept after read", rx_data, masked(d, cfg_eight_bits));
      end
      d = 8'(cfg * 29 + 3);
      send_frame(d, 1'b1, 1'b1);
      chk("R5", "flipped parity bit", {7'd0, parity_err}, {7'd0, cfg_parity_en});
      pulse_read();
      chk("R9", "read keeps error", {7'd0, parity_err}, {7'd0, cfg_parity_en});
      pulse_clear();
      chk("R9", "clear strobe", {7'd0, parity_err}, 8'd0);
    end

    // R6: low stop bit
    cfg_eight_bits = 1'b1; cfg_parity_en = 1'b0; cfg_parity_odd = 1'b0;
    send_frame(8'hA5, 1'b0, 1'b0);
    chk("R6", "framing err", {7'd0, framing_err}, 8'd1);
    chk("R6", "data still loaded", rx_data, 8'hA5);
    pulse_read();
    pulse_clear();
    chk("R9", "framing cleared", {7'd0, framing_err}, 8'd0);

    // R8: overrun
    send_frame(8'h3C, 1'b0, 1'b1);
    chk("R8", "no overrun yet", {7'd0, overrun_err}, 8'd0);
    send_frame(8'hC3, 1'b0, 1'b1);
    chk("R8", "overrun set", {7'd0, overrun_err}, 8'd1);
    chk("R8", "newer data", rx_data, 8'hC3);
    pulse_read();
    pulse_clear();

    // R2: short start pulse rejected
    rx_serial = 1'b0;
    repeat (4 * DIV) @(negedge clk);
    rx_serial = 1'b1;
    repeat (2 * BIT_CLK) @(negedge clk);
    chk("R2", "glitch no char", {7'd0, buf_full}, 8'd0);
    send_frame(8'h5A, 1'b0, 1'b1);
    chk("R2", "frame after glitch", rx_data, 8'h5A);

    // R7: receiver reset empties buffer
    chk("R7", "full before rx_reset", {7'd0, buf_full}, 8'd1);
    pulse_rxreset();
    chk("R7", "rx_reset empties", {7'd0, buf_full}, 8'd0);

    // R10: disable holds errors clear and blocks loading
    cfg_parity_en = 1'b1;
    send_frame(8'h81, 1'b1, 1'b1);
    chk("R10", "parity err before disable", {7'd0, parity_err}, 8'd1);
    pulse_read();
    prev_data = rx_data;
    @(negedge clk) rx_enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10", "errors held clear", {5'd0, parity_err, overrun_err, framing_err}, 8'd0);
    send_frame(8'h7E, 1'b1, 1'b0);
    chk("R10", "no load while disabled", {7'd0, buf_full}, 8'd0);
    chk("R10", "data unchanged", rx_data, prev_data);
    chk("R10", "errors still clear", {5'd0, parity_err, overrun_err, framing_err}, 8'd0);
    @(negedge clk) rx_enable = 1'b1;
    send_frame(8'h18, 1'b0, 1'b1);
    chk("R10", "receives after re-enable", rx_data, 8'h18);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule